// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block controls the clock domains of a microcontroller while it sleeps. Software sets a sleep-enable bit and a three-bit mode select. A one-cycle pulse then marks the point where the core executes its sleep instruction. If the enable bit is set at that moment, the controller captures the mode and drops the clock enables that the mode does not need. Each mode has its own set of clock domains that keep running and its own set of wake sources.

While the block is asleep, it samples wake requests on the always-on clock. Each request is filtered through the wake-source mask of the captured mode. An accepted wake event, or a reset request, turns the clocks back on except the CPU clock. The CPU stays halted through a programmable start-up count and then through four more stall cycles. The block then returns to the active state and emits a one-cycle completion pulse. A cause flag with that pulse tells the core whether to service an interrupt and continue after the sleep instruction, or to restart from the reset vector.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: Sleep is entered only when `sleep_exec_i` is high in the active state while `sleep_en_i` is 1. With `sleep_en_i` at 0 the pulse has no effect: the state stays active (0) and all clock enables stay at 1.
- R2: `clk_en_o` bit positions are: 0 CPU, 1 memory, 2 I/O, 3 timer, 4 external clock, 5 source oscillator, 6 watchdog, 7 divider. Mode 3'b000 (Idle) drives `clk_en_o` = 8'hFC while asleep.
- R3: Mode 3'b001 (Extended Power-Save) drives `clk_en_o` = 8'hF8 while asleep.
- R4: Mode 3'b011 (Power-Save) drives `clk_en_o` = 8'hE0 while asleep.
- R5: Mode 3'b010 (Power-Down) drives `clk_en_o` = 8'h60 while asleep. When `src_sel_i` is 0 and `src_dis_i` is 1, it drives 8'h00 instead.
- R6: The reserved modes 3'b100 to 3'b111 behave exactly as Idle, both for clocks and for wake sources.
- R7: `wake_req_i` bit positions are: 0 external interrupt, 1 pin change, 2 receiver, 3 SPI, 4 serial module, 5 EEPROM. Bits 0 and 1 wake from every mode. Bits 2 to 4 wake only from Idle. Bit 5 wakes from Idle and Extended Power-Save. A masked request leaves the block asleep.
- R8: After the wake edge the state is STARTUP (2) for exactly `startup_cyc_i` cycles and then STALL (3) for exactly 4 cycles. During both, `clk_en_o` = 8'hFE. The block then returns to ACTIVE (0), with `wake_done_o` high for exactly its first active cycle.
- R9: `sleep_rst_i` wakes the block from any sleep mode and sets `wake_cause_o` to 1 (reset vector). An interrupt wake sets it to 0. When both arrive in the same cycle, the reset wins.
- R10: The mode is captured at sleep entry. Changes to `sleep_mode_i` during sleep do not change the clock enables or the wake-source mask.
- R11: After reset the state is ACTIVE (0), `clk_en_o` = 8'hFF and `wake_done_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_en_i | input | 1 | Sleep-enable bit |
| sleep_mode_i | input | 3 | Sleep mode select |
| sleep_exec_i | input | 1 | One-cycle pulse: sleep instruction executed |
| wake_req_i | input | 6 | Wake request lines, one per source |
| sleep_rst_i | input | 1 | Reset request seen while asleep |
| src_sel_i | input | 1 | Source oscillator is selected as a clock source |
| src_dis_i | input | 1 | Source-disable control bit |
| startup_cyc_i | input | 8 | Start-up delay in cycles |
| clk_en_o | output | 8 | Per-domain clock enables |
| state_o | output | 2 | 0 ACTIVE, 1 SLEEP, 2 STARTUP, 3 STALL |
| wake_done_o | output | 1 | One-cycle pulse on return to active |
| wake_cause_o | output | 1 | 1 = reset-vector restart, 0 = interrupt service |

## Verification
Two things can happen in the same cycle while asleep: an interrupt wake and a reset wake. The bench raises an unmasked external interrupt and `sleep_rst_i` on one edge. It then checks that the full start-up and stall sequence completes and that `wake_cause_o` reads 1 next to the `wake_done_o` pulse. A second overlap is a write to the mode select during sleep alongside a request that the newer mode would accept. The bench judges that case from the unchanged clock enables and from the block staying asleep.

// File: rtl/slpclk_pkg.sv
package slpclk_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_SLEEP   = 2'd1,
    ST_STARTUP = 2'd2,
    ST_STALL   = 2'd3
  } pm_state_e;

  typedef enum logic [1:0] {
    MD_IDLE  = 2'd0,
    MD_EXTPS = 2'd1,
    MD_PS    = 2'd2,
    MD_PD    = 2'd3
  } pm_mode_e;

  localparam int NUM_DOM  = 8;
  localparam int DOM_CPU  = 0;
  localparam int DOM_MEM  = 1;
  localparam int DOM_IO   = 2;
  localparam int DOM_TMR  = 3;
  localparam int DOM_EXT  = 4;
  localparam int DOM_SRC  = 5;
  localparam int DOM_WDT  = 6;
  localparam int DOM_DIV  = 7;

  localparam int NUM_WAKE = 6;
  localparam int WK_EXT   = 0;
  localparam int WK_PCH   = 1;
  localparam int WK_RX    = 2;
  localparam int WK_SPI   = 3;
  localparam int WK_SSM   = 4;
  localparam int WK_EE    = 5;

  // Reserved selects fall back to Idle.
  function automatic pm_mode_e decode_mode(input logic [2:0] sel);
    pm_mode_e m;
    case (sel)
      3'b001:  m = MD_EXTPS;
      3'b011:  m = MD_PS;
      3'b010:  m = MD_PD;
      default: m = MD_IDLE;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/slpclk_rst_sync.sv
module slpclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/slpclk_mode_map.sv
module slpclk_mode_map
  import slpclk_pkg::*;
(
  input  pm_mode_e             mode_i,
  input  logic                 src_sel_i,
  input  logic                 src_dis_i,
  output logic [NUM_DOM-1:0]   clk_mask_o,
  output logic [NUM_WAKE-1:0]  wake_mask_o
);
  logic [NUM_DOM-1:0] keep;
  logic               src_off;

  assign src_off = src_dis_i && !src_sel_i;

  always_comb begin
    keep        = '0;
    wake_mask_o = '0;
    wake_mask_o[WK_EXT] = 1'b1;
    wake_mask_o[WK_PCH] = 1'b1;
    case (mode_i)
      MD_IDLE: begin
        keep[DOM_IO]  = 1'b1;
        keep[DOM_TMR] = 1'b1;
        keep[DOM_EXT] = 1'b1;
        keep[DOM_SRC] = 1'b1;
        keep[DOM_WDT] = 1'b1;
        keep[DOM_DIV] = 1'b1;
        wake_mask_o[WK_RX]  = 1'b1;
        wake_mask_o[WK_SPI] = 1'b1;
        wake_mask_o[WK_SSM] = 1'b1;
        wake_mask_o[WK_EE]  = 1'b1;
      end
      MD_EXTPS: begin
        keep[DOM_TMR] = 1'b1;
        keep[DOM_EXT] = 1'b1;
        keep[DOM_SRC] = 1'b1;
        keep[DOM_WDT] = 1'b1;
        keep[DOM_DIV] = 1'b1;
        wake_mask_o[WK_EE] = 1'b1;
      end
      MD_PS: begin
        keep[DOM_SRC] = 1'b1;
        keep[DOM_WDT] = 1'b1;
        keep[DOM_DIV] = 1'b1;
      end
      default: begin
        keep[DOM_SRC] = !src_off;
        keep[DOM_WDT] = !src_off;
      end
    endcase
  end

  generate
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      assign clk_mask_o[d] = keep[d];
    end
  endgenerate
endmodule

// File: rtl/slpclk_down_cnt.sv
module slpclk_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i || dec_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = val_i;
    else if (dec_i) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R8
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |-> !zero_o);
endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
  import slpclk_pkg::*;
#(
  parameter int START_W   = 8,
  parameter int STALL_CYC = 4,
  parameter int SYNC_STG  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sleep_en_i,
  input  logic [2:0]          sleep_mode_i,
  input  logic                sleep_exec_i,
  input  logic [NUM_WAKE-1:0] wake_req_i,
  input  logic                sleep_rst_i,
  input  logic                src_sel_i,
  input  logic                src_dis_i,
  input  logic [START_W-1:0]  startup_cyc_i,
  output logic [NUM_DOM-1:0]  clk_en_o,
  output logic [1:0]          state_o,
  output logic                wake_done_o,
  output logic                wake_cause_o
);
  localparam int STALL_W = $clog2(STALL_CYC) + 1;
  localparam int CNT_W   = (START_W > STALL_W) ? START_W : STALL_W;

  logic rst_n;
  slpclk_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk_i (clk_i), .rst_ni(rst_ni), .rst_no(rst_n));

  pm_state_e state_q, state_d;
  pm_mode_e  mode_q, mode_d;
  logic      cause_q, cause_d, done_q, done_d;
  logic      mode_ld, cause_ld;
  logic      cnt_load, cnt_dec, cnt_zero;
  logic [CNT_W-1:0] cnt_val;
  logic [NUM_DOM-1:0]  clk_mask;
  logic [NUM_WAKE-1:0] wake_mask;
  logic      wake_any;

  slpclk_mode_map u_map (
    .mode_i(mode_q), .src_sel_i(src_sel_i), .src_dis_i(src_dis_i),
    .clk_mask_o(clk_mask), .wake_mask_o(wake_mask));

  slpclk_down_cnt #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .load_i(cnt_load), .val_i(cnt_val),
    .dec_i(cnt_dec), .zero_o(cnt_zero));

  assign wake_any = sleep_rst_i || (|(wake_req_i & wake_mask));

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    cause_d  = cause_q;
    done_d   = 1'b0;
    mode_ld  = 1'b0;
    cause_ld = 1'b0;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    cnt_val  = '0;
    case (state_q)
      ST_ACTIVE: begin
        if (sleep_exec_i && sleep_en_i) begin
          state_d = ST_SLEEP;
          mode_d  = decode_mode(sleep_mode_i);
          mode_ld = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (wake_any) begin
          cause_d  = sleep_rst_i;
          cause_ld = 1'b1;
          cnt_load = 1'b1;
          if (startup_cyc_i == '0) begin
            state_d = ST_STALL;
            cnt_val = CNT_W'(STALL_CYC - 1);
          end else begin
            state_d = ST_STARTUP;
            cnt_val = CNT_W'(startup_cyc_i - START_W'(1));
          end
        end
      end
      ST_STARTUP: begin
        if (cnt_zero) begin
          state_d  = ST_STALL;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(STALL_CYC - 1);
        end else begin
          cnt_dec = 1'b1;
        end
      end
      default: begin
        if (cnt_zero) begin
          state_d = ST_ACTIVE;
          done_d  = 1'b1;
        end else begin
          cnt_dec = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ACTIVE;
      mode_q  <= MD_IDLE;
      cause_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (mode_ld)  mode_q  <= mode_d;
      if (cause_ld) cause_q <= cause_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_ACTIVE: clk_en_o = '1;
      ST_SLEEP:  clk_en_o = clk_mask;
      default: begin
        clk_en_o          = '1;
        clk_en_o[DOM_CPU] = 1'b0;
      end
    endcase
  end

  assign state_o      = state_q;
  assign wake_done_o  = done_q;
  assign wake_cause_o = cause_q;

  // Stall-length checker counter
  logic [STALL_W:0] stall_run_q;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)                  stall_run_q <= '0;
    else if (state_q == ST_STALL) stall_run_q <= stall_run_q + 1'b1;
    else                         stall_run_q <= '0;
  end

  // R1
  no_sleep_when_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_ACTIVE && sleep_exec_i && !sleep_en_i) |=> state_q == ST_ACTIVE);
  // R8
  stall_length_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    wake_done_o |-> (stall_run_q == (STALL_W+1)'(STALL_CYC) && state_q == ST_ACTIVE));
  // R8
  cpu_held_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q != ST_ACTIVE) |-> !clk_en_o[DOM_CPU]);
  // R9
  reset_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_SLEEP && sleep_rst_i) |=> (wake_cause_o && state_q != ST_SLEEP));
  // R10
  mode_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_SLEEP && $past(state_q) == ST_SLEEP) |-> $stable(mode_q));
endmodule

// File: tb/sleep_clk_ctrl_tb.sv
`timescale 1ns/1ps
module sleep_clk_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sleep_en;
  logic [2:0] sleep_mode;
  logic       sleep_exec;
  logic [5:0] wake_req;
  logic       sleep_rst;
  logic       src_sel;
  logic       src_dis;
  logic [7:0] startup_cyc;
  logic [7:0] clk_en;
  logic [1:0] state;
  logic       wake_done;
  logic       wake_cause;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sleep_clk_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sleep_en_i(sleep_en), .sleep_mode_i(sleep_mode),
    .sleep_exec_i(sleep_exec), .wake_req_i(wake_req), .sleep_rst_i(sleep_rst),
    .src_sel_i(src_sel), .src_dis_i(src_dis), .startup_cyc_i(startup_cyc),
    .clk_en_o(clk_en), .state_o(state), .wake_done_o(wake_done),
    .wake_cause_o(wake_cause));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [7:0] exp_clk(input logic [2:0] m, input bit ss, input bit sd);
    case (m)
      3'b001: return 8'hF8;
      3'b011: return 8'hE0;
      3'b010: return (!ss && sd) ? 8'h00 : 8'h60;
      default: return 8'hFC;
    endcase
  endfunction

  task automatic enter_sleep(input string req, input logic [2:0] m);
    sleep_en = 1'b1; sleep_mode = m; sleep_exec = 1'b1;
    step();
    sleep_exec = 1'b0;
    check({req, " enter state"}, 32'(state), 32'd1);
    check({req, " sleep clocks"}, 32'(clk_en), 32'(exp_clk(m, src_sel, src_dis)));
  endtask

  task automatic wake_seq(input string req, input logic [5:0] reqs, input bit rr,
                          input logic [7:0] s, input bit cause);
    startup_cyc = s; wake_req = reqs; sleep_rst = rr;
    step();
    wake_req = '0; sleep_rst = 1'b0;
    for (int i = 0; i < int'(s); i++) begin
      check({req, " R8 startup"}, {30'd0, state}, 32'd2);
      check({req, " R8 startup clocks"}, 32'(clk_en), 32'hFE);
      step();
    end
    for (int i = 0; i < 4; i++) begin
      check({req, " R8 stall"}, {30'd0, state}, 32'd3);
      check({req, " R8 no done"}, 32'(wake_done), 32'd0);
      step();
    end
    check({req, " R8 active"}, {30'd0, state}, 32'd0);
    check({req, " R8 done pulse"}, 32'(wake_done), 32'd1);
    check({req, " R9 cause"}, 32'(wake_cause), 32'(cause));
    check({req, " R8 clocks on"}, 32'(clk_en), 32'hFF);
    step();
    check({req, " R8 done one cycle"}, 32'(wake_done), 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    check("R11 state", 32'(state), 32'd0);
    check("R11 clocks", 32'(clk_en), 32'hFF);
    check("R11 done", 32'(wake_done), 32'd0);
  endtask

  task automatic t_disabled();
    sleep_en = 1'b0; sleep_mode = 3'b010; sleep_exec = 1'b1;
    step();
    sleep_exec = 1'b0;
    check("R1 no entry state", 32'(state), 32'd0);
    check("R1 no entry clocks", 32'(clk_en), 32'hFF);
    step();
    check("R1 still active", 32'(state), 32'd0);
  endtask

  task automatic t_idle();
    enter_sleep("R2 idle", 3'b000);
    wake_seq("R7 idle spi", 6'b001000, 1'b0, 8'd3, 1'b0);
  endtask

  task automatic t_extps_frozen();
    enter_sleep("R3 extps", 3'b001);
    sleep_mode = 3'b000;
    repeat (3) step();
    check("R10 mode kept clocks", 32'(clk_en), 32'hF8);
    wake_req = 6'b011100;
    step();
    wake_req = '0;
    check("R10 R7 masked spi/rx/ssm", 32'(state), 32'd1);
    wake_seq("R7 extps eeprom", 6'b100000, 1'b0, 8'd2, 1'b0);
  endtask

  task automatic t_ps_masked();
    enter_sleep("R4 ps", 3'b011);
    wake_req = 6'b111100;
    step();
    wake_req = '0;
    check("R7 ps masked", 32'(state), 32'd1);
    check("R7 ps clocks unchanged", 32'(clk_en), 32'hE0);
    wake_seq("R7 ps pin change", 6'b000010, 1'b0, 8'd0, 1'b0);
  endtask

  task automatic t_pd();
    src_sel = 1'b1; src_dis = 1'b1;
    enter_sleep("R5 pd selected", 3'b010);
    src_sel = 1'b0;
    step();
    check("R5 pd source off", 32'(clk_en), 32'h00);
    src_dis = 1'b0;
    step();
    check("R5 pd source on", 32'(clk_en), 32'h60);
    wake_req = 6'b100000;
    step();
    wake_req = '0;
    check("R7 pd eeprom masked", 32'(state), 32'd1);
    wake_seq("R9 pd reset wake", 6'b000000, 1'b1, 8'd1, 1'b1);
  endtask

  task automatic t_reserved();
    enter_sleep("R6 reserved", 3'b101);
    wake_seq("R6 reserved rx wake", 6'b000100, 1'b0, 8'd1, 1'b0);
    enter_sleep("R6 reserved 7", 3'b111);
    wake_seq("R6 reserved ssm wake", 6'b010000, 1'b0, 8'd0, 1'b0);
  endtask

  task automatic t_collide();
    enter_sleep("R9 idle", 3'b000);
    wake_seq("R9 reset and int", 6'b000001, 1'b1, 8'd2, 1'b1);
    enter_sleep("R9 idle again", 3'b000);
    wake_seq("R9 int only", 6'b000001, 1'b0, 8'd1, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; sleep_en = 1'b0; sleep_mode = '0; sleep_exec = 1'b0;
    wake_req = '0; sleep_rst = 1'b0; src_sel = 1'b1; src_dis = 1'b0;
    startup_cyc = '0;
    t_reset();
    t_disabled();
    t_idle();
    t_extps_frozen();
    t_ps_masked();
    t_pd();
    t_reserved();
    t_collide();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule